// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block drives the lights at a crossing of a north-south road and an east-west road. Each road has one light that is either green or red, and exactly one of the two is green at every moment. One car-detector input per road reports whether a car is waiting there. The controller has two states: north-south green and east-west green. The two green enables are decoded straight from that state and held in registers. Each red indication is the complement of its road's green.

The controller does not re-evaluate the crossing on every clock. An internal prescaler produces a one-cycle decision strobe every `TICK_CYCLES` clocks. By default that is the clock frequency times a 30-second period, and a testbench can override it with a small value. At a strobe, the green road hands over only when the other road has a car waiting. When both roads have cars waiting, the light alternates at every strobe. The detector inputs are asynchronous to the clock, so they pass through a two-stage synchronizer before the decision logic reads them.

Top module: `crossing_light_ctrl`

## Requirements
- R1: The reset is synchronous and active high. The clock edge that samples `rst` high leaves `ns_green`=1 and `ew_green`=0 and returns the prescaler to the start of its period. The first decision edge after `rst` is released is the `TICK_CYCLES`-th edge.
- R2: `ns_green` and `ew_green` always differ, so both-red and both-green never appear.
- R3: At a decision edge with north-south green, the controller switches to east-west green when the synchronized east-west detector is 1 and otherwise stays north-south green. The north-south detector has no effect in this state.
- R4: At a decision edge with east-west green, the controller switches to north-south green when the synchronized north-south detector is 1 and otherwise stays east-west green. The east-west detector has no effect in this state.
- R5: While both detectors stay at 1, the green road alternates at every decision edge.
- R6: Decision edges occur exactly every `TICK_CYCLES` clocks. On every other edge both outputs hold, whatever the detectors do.
- R7: A decision at clock edge k uses the detector levels sampled at edge k-2 through a two-flop synchronizer. A detector change that first appears after edge k-2 has no effect on the decision at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ns_car | input | 1 | North-south car detector, asynchronous |
| ew_car | input | 1 | East-west car detector, asynchronous |
| ns_green | output | 1 | North-south green enable, registered (red is its complement) |
| ew_green | output | 1 | East-west green enable, registered (red is its complement) |

## Verification
The bench drives all four detector combinations from each state and predicts the next road with its own model. It also checks that nothing moves on the edges between decisions. If a design read the wrong detector in a state, or let the waiting road's own detector matter, the road would switch on a pattern that should leave it alone. Short detector pulses between decisions and pulses that arrive one edge too late for the synchronizer test the timing. A design that sampled every clock, or that had one synchronizer stage too few, would switch early or react to a late pulse. A reset in the middle of a period checks that the prescaler restarts; a design that kept the old count would decide before the `TICK_CYCLES`-th edge after release.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic {
        ROAD_NS = 1'b0,
        ROAD_EW = 1'b1
    } road_t;

    typedef struct packed {
        road_t road;
        logic  ns_green;
        logic  ew_green;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{road: ROAD_NS, ns_green: 1'b1, ew_green: 1'b0};

    localparam int REQ_NS = 0;
    localparam int REQ_EW = 1;
    localparam int REQ_W  = 2;

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/tlc_prescaler.sv
module tlc_prescaler #(
    parameter int TICK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tlc_policy.sv
module tlc_policy
    import tlc_pkg::*;
(
    input  road_t cur,
    input  logic  ns_req,
    input  logic  ew_req,
    output road_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ROAD_NS: if (ew_req) nxt = ROAD_EW;
            ROAD_EW: if (ns_req) nxt = ROAD_NS;
            default: nxt = ROAD_NS;
        endcase
    end
endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
    import tlc_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int PERIOD_S    = 30,
    parameter int TICK_CYCLES = CLK_HZ * PERIOD_S,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ns_car,
    input  logic ew_car,
    output logic ns_green,
    output logic ew_green
);
    logic              tick_w;
    logic [REQ_W-1:0]  req_sync;
    road_t             road_nxt;
    ctrl_t             ctrl_d, ctrl_q;

    tlc_sync #(
        .WIDTH  (REQ_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ew_car, ns_car}),
        .sync_out (req_sync)
    );

    tlc_prescaler #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_w)
    );

    tlc_policy u_policy (
        .cur    (ctrl_q.road),
        .ns_req (req_sync[REQ_NS]),
        .ew_req (req_sync[REQ_EW]),
        .nxt    (road_nxt)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (tick_w) begin
            ctrl_d.road     = road_nxt;
            ctrl_d.ns_green = (road_nxt == ROAD_NS);
            ctrl_d.ew_green = (road_nxt == ROAD_EW);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RESET;
        else     ctrl_q <= ctrl_d;
    end

    assign ns_green = ctrl_q.ns_green;
    assign ew_green = ctrl_q.ew_green;
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
    parameter int TICK_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [1:0] req,
    input logic       ns_green,
    input logic       ew_green
);
    logic [31:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick) gap_q <= '0;
        else             gap_q <= gap_q + 32'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ns_green && !ew_green));

    // R2
    one_green_chk: assert property (@(posedge clk) disable iff (rst)
        ns_green != ew_green);

    // R3
    ns_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ns_green && req[1]) |=> ew_green);

    // R3
    ns_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ns_green && !req[1]) |=> ns_green);

    // R4
    ew_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ew_green && req[0]) |=> ns_green);

    // R4
    ew_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ew_green && !req[0]) |=> ew_green);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(ns_green) && $stable(ew_green)));

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == 32'(TICK_CYCLES - 1)));

    // R6
    tick_due_chk: assert property (@(posedge clk) disable iff (rst)
        (gap_q == 32'(TICK_CYCLES - 1)) |-> tick);
endmodule

bind crossing_light_ctrl tlc_checker #(
    .TICK_CYCLES (TICK_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .req      (req_sync),
    .ns_green (ns_green),
    .ew_green (ew_green)
);

// File: tb/crossing_light_ctrl_test.sv
module crossing_light_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ns_car = 1'b0;
    logic ew_car = 1'b0;
    logic ns_green, ew_green;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit cur_ew = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crossing_light_ctrl #(.TICK_CYCLES(P)) uut (
        .clk      (clk),
        .rst      (rst),
        .ns_car   (ns_car),
        .ew_car   (ew_car),
        .ns_green (ns_green),
        .ew_green (ew_green)
    );

    function automatic bit model_next(bit st_ew, bit ns, bit ew);
        return st_ew ? !ns : ew;
    endfunction

    task automatic next_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_road(string req, bit exp_ew);
        checks++;
        if (ns_green !== !exp_ew || ew_green !== exp_ew) begin
            fails++;
            $display("FAIL %s: ns_green=%b ew_green=%b expected ns_green=%b ew_green=%b",
                     req, ns_green, ew_green, !exp_ew, exp_ew);
        end
    endtask

    // one full decision period; glitch flips the detectors on edges 1..2
    task automatic run_period(string req, bit ns, bit ew, bit glitch);
        ns_car = ns;
        ew_car = ew;
        for (int e = 1; e <= P; e++) begin
            next_edge();
            if (e < P) check_road("R6 hold", cur_ew);
            if (glitch && e == 1) begin ns_car = !ns; ew_car = !ew; end
            if (glitch && e == 3) begin ns_car = ns;  ew_car = ew;  end
        end
        cur_ew = model_next(cur_ew, ns, ew);
        check_road(req, cur_ew);
    endtask

    // north-south green assumed; ew_car pulsed from edge set_at to clr_at
    task automatic late_pulse(string req, int set_at, int clr_at, bit exp_ew);
        ns_car = 1'b0;
        ew_car = 1'b0;
        for (int e = 1; e <= P; e++) begin
            next_edge();
            if (e == set_at) ew_car = 1'b1;
            if (e == clr_at) ew_car = 1'b0;
        end
        cur_ew = exp_ew;
        check_road(req, cur_ew);
    endtask

    task automatic go_to(bit want_ew);
        if (cur_ew != want_ew)
            run_period(want_ew ? "R3 setup" : "R4 setup", !want_ew, want_ew, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) next_edge();
        check_road("R1 reset", 1'b0);
        rst = 1'b0;
        cur_ew = 1'b0;

        // R3/R4: every detector combination from each state
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 4; c++) begin
                go_to(bit'(st));
                run_period(st == 0 ? "R3 sweep" : "R4 sweep", bit'(c & 1), bit'(c >> 1), 1'b0);
            end
        end

        // R5: both waiting alternates
        for (int i = 0; i < 4; i++) run_period("R5 both waiting", 1'b1, 1'b1, 1'b0);

        // R6: detector glitches between decisions
        for (int c = 0; c < 4; c++) run_period("R6 glitch", bit'(c & 1), bit'(c >> 1), 1'b1);

        // R7: synchronizer latency
        go_to(1'b0);
        late_pulse("R7 late pulse ignored", P-2, P-1, 1'b0);
        late_pulse("R7 late pulse next period", 0, 0, 1'b0);
        late_pulse("R7 pulse at k-2 taken", P-3, P-2, 1'b1);

        // R1: reset mid-period restarts prescaler
        go_to(1'b1);
        ns_car = 1'b0;
        ew_car = 1'b0;
        repeat (3) begin
            next_edge();
            check_road("R6 hold", 1'b1);
        end
        rst = 1'b1;
        next_edge();
        check_road("R1 mid-run reset", 1'b0);
        rst = 1'b0;
        cur_ew = 1'b0;
        run_period("R1 prescaler restart", 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule